// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside the command scheduler of a double-data-rate SDRAM controller. Each cycle it reads the command the scheduler issues, which is open a row, read, write, close (precharge), cut a read short, or nothing. With the command come a bank number, the address-bit-ten flag and a row number. From these it keeps, for every bank, whether a row is open and which one. It also runs the timers that decide when the bank will next take a read or write, and when it will next take an activate. The row-active minimum, the precharge time and the burst length arrive as cycle counts on input pins. The controller can therefore change them without rebuilding the block.

On a read or write that carries the address-bit-ten flag, the tracker closes the bank by itself. It does this at the first edge an explicit close would be legal: no earlier than the end of the burst, and no earlier than the row-active minimum after the activate. Any command that the bank state forbids raises a one-cycle illegal pulse and changes no state. There is no data path, so every pin is plain control or status. Nothing is stalled and there is no back-pressure: the scheduler reads the ready flags and owns the decision to issue.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank is closed, `act_rdy_o` is all ones, `rw_rdy_o`, `busy_o` and `illegal_o` are zero.
- R2: An activate (command code 1) to a bank whose `act_rdy_o` bit is set opens it after the edge: `bank_open_o` set, its row field in `bank_row_o` (bank b at bits b*ROW_W upward) equal to `row_i`, `rw_rdy_o` set and `act_rdy_o` clear. An activate to a bank that is open, or still inside its precharge time, is illegal.
- R3: A precharge (code 4) with `a10_i` low closes only the bank named by `ba_i`; other banks keep their state and rows.
- R4: A precharge with `a10_i` high closes every open bank after the edge, whatever `ba_i` holds.
- R5: A bank whose close begins at edge p reports `act_rdy_o` after edge p+tRP-1, so an activate is accepted at edge p+tRP. tRP values of 0 and 1 act as 1. Activate, read or write before that is illegal and does nothing.
- R6: A read (code 2) or write (code 3) to a bank that is not open is illegal. `illegal_o` is high for exactly the one cycle after the offending edge, and bank state is unchanged.
- R7: A precharge to a bank that is closed, already closing, or waiting on its automatic close has no effect: no illegal pulse and no restart of the precharge timer.
- R8: A read or write accepted at edge m with `a10_i` high, on a row activated at edge a, closes the bank at edge max(m+BL, a+tRAS). `busy_o` for that bank is high for the BL cycles after edge m.
- R9: Automatic close applies only to the command that carried the flag. A later read with `a10_i` low leaves the row open for good.
- R10: While an automatic close is pending, `rw_rdy_o` for that bank is clear. A read, write or activate to it is illegal, and an explicit precharge to it is ignored.
- R11: Burst terminate (code 5) ignores `ba_i` and ends the burst of the most recently accepted read: that bank's `busy_o` drops after the edge and its row stays open. If that read carried the automatic-close flag, the terminate is illegal and the burst continues.
- R12: Activate, read, write and precharge to one bank are accepted while another bank is waiting on an automatic close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate |
| ba_i | input | log2(NUM_BANKS) | Target bank |
| a10_i | input | 1 | All-bank precharge / automatic-close flag |
| row_i | input | ROW_W | Row number for activate |
| t_ras_i | input | CNT_W | Row-active minimum in cycles |
| t_rp_i | input | CNT_W | Precharge time in cycles |
| burst_len_i | input | CNT_W | Burst length in clock cycles |
| bank_open_o | output | NUM_BANKS | Row open, per bank |
| bank_row_o | output | NUM_BANKS*ROW_W | Open row, per bank |
| rw_rdy_o | output | NUM_BANKS | Read or write may be issued |
| act_rdy_o | output | NUM_BANKS | Activate may be issued |
| busy_o | output | NUM_BANKS | Data burst in progress |
| illegal_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
The hardest point to reach is the automatic close. Its edge depends on two timers that run at once, so the stimulus sets one case where the row-active minimum ends last and another where the burst ends last. In both, the bank is sampled in the cycle before the predicted edge and again in the cycle after it. Burst terminate gets the same care. The stimulus opens two banks and reads from both, so that only the most recent read may be cut short. It then places a terminate after a read that carries the automatic-close flag, where the terminate must be refused.

// File: rtl/sdram_bank_pkg.sv
`timescale 1ns/1ps
package sdram_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_e;

  // per-bank decoded request
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic trunc;
    logic ap;
  } bank_req_t;
endpackage

// File: rtl/sdram_cmd_route.sv
`timescale 1ns/1ps
module sdram_cmd_route
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]      cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic [NUM_BANKS-1:0] trunc_i,
  output bank_req_t       req_o [NUM_BANKS]
);
  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (ba_i == BA_W'(b));
    always_comb begin
      req_o[b].act   = (cmd == CMD_ACT) && sel;
      req_o[b].rd    = (cmd == CMD_RD)  && sel;
      req_o[b].wr    = (cmd == CMD_WR)  && sel;
      // all-bank close ignores the bank number
      req_o[b].pre   = (cmd == CMD_PRE) && (a10_i || sel);
      req_o[b].trunc = trunc_i[b];
      req_o[b].ap    = a10_i;
    end
  end
endmodule

// File: rtl/sdram_burst_term.sv
`timescale 1ns/1ps
module sdram_burst_term
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [NUM_BANKS-1:0] rw_rdy_i,
  output logic [NUM_BANKS-1:0] trunc_o,
  output logic                 bad_o
);
  logic [BA_W-1:0] last_ba_q;
  logic            last_ap_q;
  logic            have_q;

  // remember the most recent accepted read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ba_q <= '0;
      last_ap_q <= 1'b0;
      have_q    <= 1'b0;
    end else if (cmd_e'(cmd_i) == CMD_RD && rw_rdy_i[ba_i]) begin
      last_ba_q <= ba_i;
      last_ap_q <= a10_i;
      have_q    <= 1'b1;
    end
  end

  always_comb begin
    trunc_o = '0;
    bad_o   = 1'b0;
    if (cmd_e'(cmd_i) == CMD_BST && have_q) begin
      if (last_ap_q) bad_o = 1'b1;
      else           trunc_o[last_ba_q] = 1'b1;
    end
  end
endmodule

// File: rtl/sdram_bank_slot.sv
`timescale 1ns/1ps
module sdram_bank_slot
  import sdram_bank_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_req_t        req_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] t_ras_i,
  input  logic [CNT_W-1:0] t_rp_i,
  input  logic [CNT_W-1:0] blen_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_rdy_o,
  output logic             act_rdy_o,
  output logic             busy_o,
  output logic             bad_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bank_st_e         st_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] ras_q, trp_q, bcnt_q;
  logic             ap_q;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  // a counter at or below one means the coming edge is legal
  logic in_trp, act_ok, rw_ok, ap_fire, pre_go;
  logic open_go, close_go, rw_go;

  assign in_trp   = (st_q == BK_PRECH) && (trp_q > ONE);
  assign act_ok   = (st_q == BK_IDLE) || ((st_q == BK_PRECH) && !in_trp);
  assign rw_ok    = (st_q == BK_OPEN) && !ap_q;
  assign ap_fire  = (st_q == BK_OPEN) && ap_q && (ras_q <= ONE) && (bcnt_q <= ONE);
  assign pre_go   = req_i.pre && rw_ok;
  assign open_go  = req_i.act && act_ok;
  assign close_go = ap_fire || pre_go;
  assign rw_go    = (req_i.rd || req_i.wr) && rw_ok;

  assign bad_o = (req_i.act && !act_ok) || ((req_i.rd || req_i.wr) && !rw_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      row_q  <= '0;
      ras_q  <= '0;
      trp_q  <= '0;
      bcnt_q <= '0;
      ap_q   <= 1'b0;
    end else begin
      ras_q  <= dec(ras_q);
      trp_q  <= dec(trp_q);
      bcnt_q <= req_i.trunc ? '0 : dec(bcnt_q);
      if (open_go) begin
        st_q  <= BK_OPEN;
        row_q <= row_i;
        ras_q <= t_ras_i;
        ap_q  <= 1'b0;
      end else if (close_go) begin
        st_q  <= BK_PRECH;
        trp_q <= t_rp_i;
        ap_q  <= 1'b0;
      end else if (rw_go) begin
        bcnt_q <= blen_i;
        ap_q   <= req_i.ap;
      end else if (st_q == BK_PRECH && act_ok) begin
        st_q <= BK_IDLE;
      end
    end
  end

  assign open_o    = (st_q == BK_OPEN);
  assign row_o     = row_q;
  assign rw_rdy_o  = rw_ok;
  assign act_rdy_o = act_ok;
  assign busy_o    = (bcnt_q != '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int CNT_W     = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cmd_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic                       a10_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [CNT_W-1:0]           t_ras_i,
  input  logic [CNT_W-1:0]           t_rp_i,
  input  logic [CNT_W-1:0]           burst_len_i,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  output logic [NUM_BANKS-1:0]       rw_rdy_o,
  output logic [NUM_BANKS-1:0]       act_rdy_o,
  output logic [NUM_BANKS-1:0]       busy_o,
  output logic                       illegal_o
);
  bank_req_t            req [NUM_BANKS];
  logic [NUM_BANKS-1:0] trunc;
  logic [NUM_BANKS-1:0] bank_bad;
  logic                 bst_bad;
  logic                 illegal_q;

  sdram_burst_term #(.NUM_BANKS(NUM_BANKS)) u_term (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .ba_i     (ba_i),
    .a10_i    (a10_i),
    .rw_rdy_i (rw_rdy_o),
    .trunc_o  (trunc),
    .bad_o    (bst_bad)
  );

  sdram_cmd_route #(.NUM_BANKS(NUM_BANKS)) u_route (
    .cmd_i   (cmd_i),
    .ba_i    (ba_i),
    .a10_i   (a10_i),
    .trunc_i (trunc),
    .req_o   (req)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req[b]),
      .row_i     (row_i),
      .t_ras_i   (t_ras_i),
      .t_rp_i    (t_rp_i),
      .blen_i    (burst_len_i),
      .open_o    (bank_open_o[b]),
      .row_o     (bank_row_o[b*ROW_W +: ROW_W]),
      .rw_rdy_o  (rw_rdy_o[b]),
      .act_rdy_o (act_rdy_o[b]),
      .busy_o    (busy_o[b]),
      .bad_o     (bank_bad[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= (|bank_bad) || bst_bad;
  end

  assign illegal_o = illegal_q;
endmodule

// File: rtl/sdram_bank_tracker_chk.sv
`timescale 1ns/1ps
module sdram_bank_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int CNT_W     = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 cmd_i,
  input logic [BA_W-1:0]            ba_i,
  input logic                       a10_i,
  input logic [ROW_W-1:0]           row_i,
  input logic [CNT_W-1:0]           burst_len_i,
  input logic [NUM_BANKS-1:0]       bank_open_o,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  input logic [NUM_BANKS-1:0]       rw_rdy_o,
  input logic [NUM_BANKS-1:0]       act_rdy_o,
  input logic [NUM_BANKS-1:0]       busy_o,
  input logic                       illegal_o
);
  AST_ILLEGAL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($past(cmd_i) != 3'd0)); // R6

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd1 && ba_i == BA_W'(b) && act_rdy_o[b]) |=>
      (bank_open_o[b] && bank_row_o[b*ROW_W +: ROW_W] == $past(row_i))); // R2
    AST_RDY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rw_rdy_o[b] && act_rdy_o[b])); // R2
    AST_ALL_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd4 && a10_i && rw_rdy_o[b]) |=> !bank_open_o[b]); // R4
    AST_RW_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i == 3'd2 || cmd_i == 3'd3) && ba_i == BA_W'(b) && !bank_open_o[b]) |=> illegal_o); // R6
    AST_IDLE_PRE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd4 && !bank_open_o[b] && act_rdy_o[b]) |=> (act_rdy_o[b] && !illegal_o)); // R7
    AST_BURST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i == 3'd2 || cmd_i == 3'd3) && ba_i == BA_W'(b) && rw_rdy_o[b] && burst_len_i != '0) |=> busy_o[b]); // R8
  end
endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .ba_i        (ba_i),
  .a10_i       (a10_i),
  .row_i       (row_i),
  .burst_len_i (burst_len_i),
  .bank_open_o (bank_open_o),
  .bank_row_o  (bank_row_o),
  .rw_rdy_o    (rw_rdy_o),
  .act_rdy_o   (act_rdy_o),
  .busy_o      (busy_o),
  .illegal_o   (illegal_o)
);

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int CW = 8;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_i = NOP;
  logic [1:0]    ba_i = '0;
  logic          a10_i = 1'b0;
  logic [RW-1:0] row_i = '0;
  logic [CW-1:0] t_ras_i = 8'd4;
  logic [CW-1:0] t_rp_i = 8'd4;
  logic [CW-1:0] burst_len_i = 8'd2;
  logic [NB-1:0] bank_open_o, rw_rdy_o, act_rdy_o, busy_o;
  logic [NB*RW-1:0] bank_row_o;
  logic          illegal_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ba_i(ba_i), .a10_i(a10_i),
    .row_i(row_i), .t_ras_i(t_ras_i), .t_rp_i(t_rp_i), .burst_len_i(burst_len_i),
    .bank_open_o(bank_open_o), .bank_row_o(bank_row_o), .rw_rdy_o(rw_rdy_o),
    .act_rdy_o(act_rdy_o), .busy_o(busy_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // drive at a falling edge; on return the command's rising edge has passed
  task automatic issue(input logic [2:0] c, input int b, input logic a, input logic [RW-1:0] r);
    cmd_i = c; ba_i = b[1:0]; a10_i = a; row_i = r;
    @(negedge clk);
    cmd_i = NOP; a10_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    issue(PRE, 0, 1'b1, '0);
    idle(40);
  endtask

  function automatic logic [RW-1:0] row_of(input int b);
    return bank_row_o[b*RW +: RW];
  endfunction

  task automatic t_reset();
    chk("R1", "open", bank_open_o, 4'h0);
    chk("R1", "act_rdy", act_rdy_o, 4'hf);
    chk("R1", "rw_rdy", rw_rdy_o, 4'h0);
    chk("R1", "busy", busy_o, 4'h0);
    chk("R1", "illegal", illegal_o, 1'b0);
  endtask

  task automatic t_activate();
    issue(ACT, 1, 1'b0, 13'h123);
    chk("R2", "open1", bank_open_o[1], 1'b1);
    chk("R2", "row1", row_of(1), 13'h123);
    chk("R2", "rw_rdy1", rw_rdy_o[1], 1'b1);
    chk("R2", "act_rdy1", act_rdy_o[1], 1'b0);
    chk("R2", "illegal", illegal_o, 1'b0);
    issue(ACT, 1, 1'b0, 13'h055);
    chk("R2", "act on open illegal", illegal_o, 1'b1);
    chk("R2", "row kept", row_of(1), 13'h123);
    settle();
  endtask

  task automatic t_single_pre();
    issue(ACT, 0, 1'b0, 13'h011);
    issue(ACT, 2, 1'b0, 13'h022);
    issue(PRE, 2, 1'b0, '0);
    chk("R3", "open2", bank_open_o[2], 1'b0);
    chk("R3", "open0", bank_open_o[0], 1'b1);
    chk("R3", "row0", row_of(0), 13'h011);
    settle();
  endtask

  task automatic t_all_pre();
    issue(ACT, 0, 1'b0, 13'h1);
    issue(ACT, 1, 1'b0, 13'h2);
    issue(ACT, 3, 1'b0, 13'h3);
    issue(PRE, 2, 1'b1, '0);
    chk("R4", "open all", bank_open_o, 4'h0);
    chk("R4", "act_rdy", act_rdy_o, 4'b0100);
    settle();
  endtask

  task automatic t_trp();
    t_rp_i = 8'd4;
    issue(ACT, 0, 1'b0, 13'h5);
    issue(PRE, 0, 1'b0, '0);
    chk("R5", "act_rdy at p", act_rdy_o[0], 1'b0);
    issue(ACT, 0, 1'b0, 13'h6);
    chk("R5", "early act illegal", illegal_o, 1'b1);
    chk("R5", "early act no open", bank_open_o[0], 1'b0);
    idle(1);
    chk("R5", "act_rdy at p+2", act_rdy_o[0], 1'b0);
    idle(1);
    chk("R5", "act_rdy at p+3", act_rdy_o[0], 1'b1);
    issue(ACT, 0, 1'b0, 13'h7);
    chk("R5", "act at p+tRP", bank_open_o[0], 1'b1);
    chk("R5", "no illegal", illegal_o, 1'b0);
    settle();
  endtask

  task automatic t_rw_idle();
    issue(RD, 2, 1'b0, '0);
    chk("R6", "rd idle illegal", illegal_o, 1'b1);
    chk("R6", "rd idle open", bank_open_o[2], 1'b0);
    idle(1);
    chk("R6", "pulse ends", illegal_o, 1'b0);
    issue(WR, 3, 1'b0, '0);
    chk("R6", "wr idle illegal", illegal_o, 1'b1);
    issue(ACT, 1, 1'b0, 13'h9);
    issue(PRE, 1, 1'b0, '0);
    issue(RD, 1, 1'b0, '0);
    chk("R6", "rd in tRP illegal", illegal_o, 1'b1);
    chk("R6", "busy stays low", busy_o[1], 1'b0);
    settle();
  endtask

  task automatic t_redundant();
    issue(PRE, 3, 1'b0, '0);
    chk("R7", "pre idle no illegal", illegal_o, 1'b0);
    chk("R7", "pre idle act_rdy", act_rdy_o[3], 1'b1);
    issue(ACT, 3, 1'b0, 13'h4);
    issue(PRE, 3, 1'b0, '0);
    issue(PRE, 3, 1'b0, '0);
    chk("R7", "pre closing no illegal", illegal_o, 1'b0);
    idle(1);
    chk("R7", "act_rdy p+2", act_rdy_o[3], 1'b0);
    idle(1);
    chk("R7", "timer not restarted", act_rdy_o[3], 1'b1);
    settle();
  endtask

  task automatic t_ap(input int ras, input int bl, input logic [2:0] rw);
    int d;
    t_ras_i = CW'(ras); burst_len_i = CW'(bl); t_rp_i = 8'd4;
    d = (bl > ras - 1) ? bl : ras - 1;
    issue(ACT, 0, 1'b0, 13'h3c);
    issue(rw, 0, 1'b1, '0);
    chk("R8", "busy after cmd", busy_o[0], 1'b1);
    if (d > 1) begin
      idle(d - 1);
      chk("R8", "open before close edge", bank_open_o[0], 1'b1);
    end
    idle(1);
    chk("R8", "closed at close edge", bank_open_o[0], 1'b0);
    chk("R8", "busy done", busy_o[0], 1'b0);
    chk("R5", "act_rdy after ap", act_rdy_o[0], 1'b0);
    idle(2);
    chk("R5", "act_rdy ap+2", act_rdy_o[0], 1'b0);
    idle(1);
    chk("R5", "act_rdy ap+3", act_rdy_o[0], 1'b1);
    settle();
  endtask

  task automatic t_nonpersist();
    t_ras_i = 8'd2; burst_len_i = 8'd2;
    issue(ACT, 1, 1'b0, 13'h77);
    issue(RD, 1, 1'b1, '0);
    idle(10);
    chk("R9", "ap read closes", bank_open_o[1], 1'b0);
    issue(ACT, 1, 1'b0, 13'h78);
    issue(RD, 1, 1'b0, '0);
    idle(20);
    chk("R9", "plain read stays open", bank_open_o[1], 1'b1);
    chk("R9", "rw_rdy", rw_rdy_o[1], 1'b1);
    settle();
  endtask

  task automatic t_ap_block();
    t_ras_i = 8'd10; burst_len_i = 8'd2;
    issue(ACT, 2, 1'b0, 13'h66);
    issue(RD, 2, 1'b1, '0);
    chk("R10", "rw_rdy clear", rw_rdy_o[2], 1'b0);
    chk("R10", "still open", bank_open_o[2], 1'b1);
    issue(RD, 2, 1'b0, '0);
    chk("R10", "rd during ap illegal", illegal_o, 1'b1);
    issue(PRE, 2, 1'b0, '0);
    chk("R10", "pre during ap ignored", illegal_o, 1'b0);
    chk("R10", "pre did not close", bank_open_o[2], 1'b1);
    issue(ACT, 2, 1'b0, 13'h1);
    chk("R10", "act during ap illegal", illegal_o, 1'b1);
    settle();
  endtask

  task automatic t_bst();
    t_ras_i = 8'd2; burst_len_i = 8'd8;
    issue(ACT, 0, 1'b0, 13'h40);
    issue(RD, 0, 1'b0, '0);
    chk("R11", "busy before term", busy_o[0], 1'b1);
    issue(BST, 3, 1'b0, '0);
    chk("R11", "busy cut", busy_o[0], 1'b0);
    chk("R11", "row open", bank_open_o[0], 1'b1);
    chk("R11", "no illegal", illegal_o, 1'b0);
    issue(RD, 0, 1'b1, '0);
    issue(BST, 0, 1'b0, '0);
    chk("R11", "term after ap read illegal", illegal_o, 1'b1);
    chk("R11", "ap burst continues", busy_o[0], 1'b1);
    settle();
    issue(ACT, 1, 1'b0, 13'h41);
    issue(ACT, 2, 1'b0, 13'h42);
    issue(RD, 1, 1'b0, '0);
    issue(RD, 2, 1'b0, '0);
    issue(BST, 1, 1'b0, '0);
    chk("R11", "latest read cut", busy_o[2], 1'b0);
    chk("R11", "older read runs", busy_o[1], 1'b1);
    settle();
  endtask

  task automatic t_other_banks();
    t_ras_i = 8'd10; burst_len_i = 8'd2;
    issue(ACT, 0, 1'b0, 13'h10);
    issue(RD, 0, 1'b1, '0);
    issue(ACT, 1, 1'b0, 13'h20);
    chk("R12", "act other bank", bank_open_o[1], 1'b1);
    chk("R12", "act no illegal", illegal_o, 1'b0);
    issue(RD, 1, 1'b0, '0);
    chk("R12", "rd other bank", busy_o[1], 1'b1);
    chk("R12", "rd no illegal", illegal_o, 1'b0);
    issue(PRE, 1, 1'b0, '0);
    chk("R12", "pre other bank", bank_open_o[1], 1'b0);
    chk("R12", "ap bank still open", bank_open_o[0], 1'b1);
    settle();
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_activate();
    t_single_pre();
    t_all_pre();
    t_trp();
    t_rw_idle();
    t_redundant();
    t_ap(8, 2, RD);
    t_ap(2, 5, WR);
    t_ap(1, 1, RD);
    t_nonpersist();
    t_ap_block();
    t_bst();
    t_other_banks();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule